// File: doc/BRIEF.md
# Paired-Output Print Nozzle Decoder

This block turns a 4-bit select code into on/off enables for 28 low-side nozzle driver outputs. The outputs form two banks of 14. The lower bank holds outputs 0 to 13 and the upper bank holds outputs 14 to 27. Each valid code picks a mirrored pair of outputs: output n in the lower bank and output 27−n in the upper bank. The two highest codes are reserved and leave every output off.

An output fires only when four conditions hold together:
- it is selected by the code;
- the active-low strobe of its bank is low;
- the active-high chip enable is high;
- the power-on lockout has been released.

The lockout is a counter. An asynchronous reset restarts it, and it holds all outputs off for a parameterised number of clock cycles after reset is released.

All outputs are registered on the system clock, so they change without glitches. The on-time of an output follows the low pulse of its strobe, in whole clock cycles.

Top module: `nozzle_pair_decoder`

## Requirements
- R1: The select input `sel` is plain binary with bit 0 as LSB. A code n from 0 to 13 turns on output n (lower bank) and output 27−n (upper bank), and no other output. Output k is bit k of `drive`.
- R2: `bank_lo_stb_n` gates outputs 0..13 and `bank_hi_stb_n` gates outputs 14..27. A selected output is on only while its bank strobe is low. While a strobe is high, every output of its bank is off.
- R3: Codes 14 and 15 leave all 28 outputs off, whatever the strobes and the chip enable are.
- R4: While `chip_en` is low, all outputs are off.
- R5: After `rst_n` rises, all outputs stay off through the first LOCK_CYCLES rising clock edges (16 by default). The first edge at which an output can turn on is edge LOCK_CYCLES+1.
- R6: At no time are more than two outputs on.
- R7: `drive` is registered. A change of `sel`, a strobe or `chip_en` shows on `drive` at the first rising clock edge after the change. An output turns off at the first edge after its strobe returns high, and the other bank is not affected.
- R8: A low level on `rst_n` clears `drive` at once, without waiting for a clock edge. It also restarts the lockout of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the lockout |
| sel | input | 4 | Nozzle pair select code |
| bank_lo_stb_n | input | 1 | Active-low strobe for outputs 0..13 |
| bank_hi_stb_n | input | 1 | Active-low strobe for outputs 14..27 |
| chip_en | input | 1 | Active-high chip enable |
| drive | output | 28 | Registered output enables; bit k drives output k |

## Verification
The lockout release and the first firing of a pair can fall on the same clock edge. The bench holds both strobes low, chip enable high and code 0 through the whole reset and lockout period. It then checks that `drive` is zero after each of the first 16 edges, and that outputs 0 and 27 appear exactly at edge 17.

A strobe release in one bank can also coincide with a firing in the other bank. The bench raises one strobe while the other stays low, and judges that only the released bank drops at the next edge.

The full sweep then covers every code against all four strobe combinations with chip enable both high and low. Each result is compared with the truth table computed in the bench.

// File: rtl/npd_pkg.sv
package npd_pkg;

    // Outputs per bank and derived totals.
    localparam int unsigned BANK_OUTS = 14;
    localparam int unsigned NUM_OUTS  = 2 * BANK_OUTS;
    localparam int unsigned SEL_W     = $clog2(BANK_OUTS + 1);

    typedef logic [BANK_OUTS-1:0] bank_vec_t;
    typedef logic [NUM_OUTS-1:0]  out_vec_t;

    // Registered state of the output stage.
    typedef struct packed {
        out_vec_t drive;
    } out_state_t;

endpackage

// File: rtl/npd_lockout.sv
module npd_lockout #(
    parameter int unsigned LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.cnt == LIMIT);

    // The counter never passes its limit.
    AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT) else $error("lockout counter overran");  // R5

    // Once released, the lockout stays released until reset.
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready) else $error("lockout re-engaged");  // R5

endmodule

// File: rtl/npd_pair_decode.sv
module npd_pair_decode
    import npd_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output bank_vec_t        lo_pick,
    output bank_vec_t        hi_pick
);
    // Lower-bank output i answers code i. Upper-bank slot j is output
    // BANK_OUTS+j, which mirrors code (BANK_OUTS-1-j). Codes at or above
    // BANK_OUTS match no slot and so select nothing.
    for (genvar i = 0; i < BANK_OUTS; i++) begin : g_slot
        localparam logic [SEL_W-1:0] LO_CODE = SEL_W'(i);
        localparam logic [SEL_W-1:0] HI_CODE = SEL_W'(BANK_OUTS - 1 - i);
        assign lo_pick[i] = (sel == LO_CODE);
        assign hi_pick[i] = (sel == HI_CODE);
    end

    always_comb begin
        AST_DECODE_ONEHOT: assert ($onehot0(lo_pick) && $onehot0(hi_pick))
            else $error("decoder picked several outputs in a bank");  // R1
    end

endmodule

// File: rtl/nozzle_pair_decoder.sv
module nozzle_pair_decoder
    import npd_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                bank_lo_stb_n,
    input  logic                bank_hi_stb_n,
    input  logic                chip_en,
    output logic [NUM_OUTS-1:0] drive
);
    localparam logic [SEL_W-1:0] FIRST_RESERVED = SEL_W'(BANK_OUTS);

    logic       lock_ready;
    bank_vec_t  lo_pick;
    bank_vec_t  hi_pick;
    out_state_t st_d, st_q;

    npd_lockout #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) u_lockout (
        .clk  (clk),
        .rst_n(rst_n),
        .ready(lock_ready)
    );

    npd_pair_decode u_decode (
        .sel    (sel),
        .lo_pick(lo_pick),
        .hi_pick(hi_pick)
    );

    always_comb begin
        st_d.drive = '0;
        if (lock_ready && chip_en) begin
            st_d.drive = {hi_pick & {BANK_OUTS{~bank_hi_stb_n}},
                          lo_pick & {BANK_OUTS{~bank_lo_stb_n}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive = st_q.drive;

    AST_MAX_TWO_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive) <= 2) else $error("more than two outputs on");  // R6

    AST_LOCKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ready |=> (drive == '0)) else $error("output fired in lockout");  // R5

    AST_CE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (drive == '0)) else $error("output on without chip enable");  // R4

    AST_RESERVED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= FIRST_RESERVED) |=> (drive == '0)) else $error("reserved code fired");  // R3

    AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_lo_stb_n |=> (drive[BANK_OUTS-1:0] == '0)) else $error("lower bank on with strobe high");  // R2

    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_hi_stb_n |=> (drive[NUM_OUTS-1:BANK_OUTS] == '0)) else $error("upper bank on with strobe high");  // R2

endmodule

// File: tb/nozzle_pair_decoder_tb.sv
module nozzle_pair_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic        lo_n = 1'b0;
    logic        hi_n = 1'b0;
    logic        ce = 1'b1;
    logic [27:0] drive;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nozzle_pair_decoder #(.LOCK_CYCLES(LOCK)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .bank_lo_stb_n(lo_n),
        .bank_hi_stb_n(hi_n),
        .chip_en      (ce),
        .drive        (drive)
    );

    function automatic logic [27:0] expect_drive(input int code, input logic l_n,
                                                 input logic h_n, input logic en);
        logic [27:0] m;
        m = '0;
        if (en && code < 14) begin
            if (!l_n) m[code] = 1'b1;
            if (!h_n) m[27 - code] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input logic [27:0] exp, input string req);
        total++;
        if (drive !== exp) begin
            bad++;
            $display("FAIL %s: drive=%h expected=%h", req, drive, exp);
        end
        total++;
        if ($countones(drive) > 2) begin
            bad++;
            $display("FAIL R6: drive=%h has %0d on, expected at most 2",
                     drive, $countones(drive));
        end
    endtask

    // Drive at negedge, let one rising edge pass, sample at the next negedge.
    task automatic step(input int code, input logic l_n, input logic h_n, input logic en);
        sel = 4'(code); lo_n = l_n; hi_n = h_n; ce = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state (R8): drive low during reset.
        #3;
        check('0, "R8 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R5: strobes active, ce high, code 0 throughout the lockout.
        for (int k = 1; k <= LOCK; k++) begin
            @(posedge clk);
            @(negedge clk);
            check('0, "R5 lockout");
        end
        @(posedge clk);
        @(negedge clk);
        check(expect_drive(0, 1'b0, 1'b0, 1'b1), "R5 first fire");

        // Sweep every code, strobe pair and chip enable (R1 R2 R3 R4).
        for (int code = 0; code < 16; code++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    step(code, s[0], s[1], e[0]);
                    if (code >= 14) check(expect_drive(code, s[0], s[1], e[0]), "R3 reserved");
                    else if (e == 0) check(expect_drive(code, s[0], s[1], e[0]), "R4 chip enable");
                    else if (s != 0) check(expect_drive(code, s[0], s[1], e[0]), "R2 strobe gate");
                    else check(expect_drive(code, s[0], s[1], e[0]), "R1 pair map");
                end
            end
        end

        // R7: one-edge latency; releasing one strobe leaves the other bank on.
        step(5, 1'b0, 1'b0, 1'b1);
        check(expect_drive(5, 1'b0, 1'b0, 1'b1), "R7 on");
        lo_n = 1'b1;
        #1;
        check(expect_drive(5, 1'b0, 1'b0, 1'b1), "R7 no change before edge");
        @(posedge clk);
        @(negedge clk);
        check(expect_drive(5, 1'b1, 1'b0, 1'b1), "R7 lower off one edge later");
        step(6, 1'b0, 1'b0, 1'b1);
        check(expect_drive(6, 1'b0, 1'b0, 1'b1), "R7 select change");

        // R8: asynchronous clear and lockout restart.
        #2;
        rst_n = 1'b0;
        #1;
        check('0, "R8 async clear");
        @(negedge clk);
        rst_n = 1'b1;
        step(6, 1'b0, 1'b0, 1'b1);
        check('0, "R8 lockout restarted");
        for (int k = 2; k <= LOCK; k++) step(6, 1'b0, 1'b0, 1'b1);
        check('0, "R8 still locked at edge 16");
        step(6, 1'b0, 1'b0, 1'b1);
        check(expect_drive(6, 1'b0, 1'b0, 1'b1), "R8 release after restart");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule